// File: doc/BRIEF.md
# UART Receive Character Screener with Idle Closing

This block sits after a UART bit-level receiver. Each bit of a character arrives as three line samples taken across the bit cell. When the character is complete, the assembled byte arrives with a parity verdict. From these the block decides whether the byte goes into the currently open receive buffer, whether that buffer is closed, and which status bit the close carries. It also raises a one-cycle receive interrupt when interrupts are enabled. In multidrop operation it asks the receiver to go back to hunting for an address.

Errors are ranked, and each rank closes the buffer in its own way. A lost carrier abandons the character. An overrun or a parity error stores the character and then closes the buffer. Noise stores the character and leaves the buffer open. All-ones characters are treated as line idle. They are counted against a programmable limit, and when the limit is reached the buffer is closed without status. Two saturating counters record parity and noise events.

Top module: `rxs_top`

## Requirements
- R1: After reset every output is 0 and both event counters read 0.
- R2: A character is tagged carrier-lost when it arrives with carrier control enabled and the carrier flag high. Such a character is not written and increments no counter. If a buffer is open, it is closed with only the carrier-lost status bit set. If no buffer is open, no close is produced.
- R3: A character that arrives while the FIFO-full flag is high, and is not carrier-lost, is written. It then closes the buffer with only the overrun status bit set, even when its parity is also bad.
- R4: A character with bad parity, and no carrier loss or overrun, is written. It then closes the buffer with only the parity status bit set. Every character with bad parity that is not carrier-lost adds one to the parity counter.
- R5: A bit sample triple that is neither 3'b000 nor 3'b111 marks the character that follows as noisy. A noisy character, unless carrier-lost, adds one to the noise counter, is written, and does not by itself close the buffer.
- R6: While the synchronous-mode flag is high, sample disagreement is ignored and the noise counter does not change.
- R7: With the multidrop flag high, a carrier-lost, overrun or parity character produces a one-cycle hunt request. A clean or noise-only character produces none.
- R8: A byte of 8'hFF with good parity, no overrun and no carrier loss is an idle character. It is not written. It increments the idle count, and when the count reaches the nonzero programmed maximum, the open buffer is closed with no status bits set and the count returns to 0.
- R9: A programmed maximum of 0 means idle characters never close a buffer.
- R10: Any character that is neither idle nor carrier-lost resets the idle count to 0. A carrier-lost character leaves the count unchanged.
- R11: If the idle limit is reached while no buffer is open, no close and no interrupt are produced.
- R12: The interrupt is high for exactly the cycles in which a close is reported and the interrupt enable was high. A buffer opens on the first written character after a close.
- R13: The event counters saturate at all ones. A synchronous clear sets both to 0 and takes priority over a same-cycle increment.
- R14: Write, close, interrupt and hunt outputs appear in the cycle after the character strobe and are 0 in any cycle that does not follow a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_smp_vld | input | 1 | One bit's three samples are present |
| bit_smp | input | 3 | The three samples of that bit |
| chr_vld | input | 1 | Character complete strobe |
| chr_data | input | DATA_W | Assembled byte |
| chr_par_bad | input | 1 | Parity check failed for this character |
| cd_ctl_en | input | 1 | Carrier flag controls reception |
| cd_lost | input | 1 | Carrier dropped during this character |
| fifo_full | input | 1 | Receive FIFO had no room for this character |
| sync_mode | input | 1 | Channel runs synchronously; noise checking off |
| mdrop_mode | input | 1 | Multidrop operation; errors request hunt |
| idle_max | input | IDLE_W | Idle characters that close the buffer; 0 disables |
| irq_en | input | 1 | Receive interrupt enable |
| cnt_clr | input | 1 | Synchronous clear of both event counters |
| wr_vld | output | 1 | Byte written into the open buffer |
| wr_data | output | DATA_W | Byte being written |
| close_vld | output | 1 | Current buffer is closed |
| close_ovr | output | 1 | Close status: overrun |
| close_cdl | output | 1 | Close status: carrier lost |
| close_par | output | 1 | Close status: parity |
| irq | output | 1 | One-cycle receive interrupt |
| hunt_req | output | 1 | Request to re-enter hunt mode |
| par_cnt | output | CNT_W | Parity event counter |
| noise_cnt | output | CNT_W | Noise event counter |

## Verification
A behavioural model in the bench tracks buffer state, the idle count and both counters, and is compared with every output on each clock. Stacked faults (overrun with bad parity, carrier loss with bad parity) separate the ranking from the counting. Noise injected in one bit, with and without the synchronous flag, separates detection from its suppression. Idle runs broken by a data byte, run with a closed buffer, and run with a zero limit separate the count, its reset and the open-buffer condition. A long run of bad-parity characters drives the counter into saturation before the clear.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

  // error rank, higher value wins
  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_PAR  = 2'd1,
    ERR_OVR  = 2'd2,
    ERR_CDL  = 2'd3
  } err_e;

  typedef struct packed {
    logic wr;         // byte goes into buffer
    err_e err;        // highest-ranked closing error
    logic hunt;       // multidrop hunt request
    logic idle_step;  // clean all-ones character
    logic idle_clr;   // character restarts idle run
    logic inc_par;    // parity counter event
    logic inc_noise;  // noise counter event
  } chr_evt_t;

  // true when the three samples of a bit agree
  function automatic logic smp_agree(input logic [2:0] s);
    return (s == 3'b000) || (s == 3'b111);
  endfunction

  // pick the highest-ranked error of one character
  function automatic err_e pick_err(input logic cdl, input logic ovr, input logic par);
    if (cdl)      return ERR_CDL;
    else if (ovr) return ERR_OVR;
    else if (par) return ERR_PAR;
    else          return ERR_NONE;
  endfunction

endpackage

// File: rtl/rxs_noise_track.sv
module rxs_noise_track (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       smp_vld,
  input  logic [2:0] smp,
  input  logic       sync_mode,
  input  logic       chr_vld,
  output logic       chr_noisy
);
  import rxs_pkg::*;

  logic seen_q;
  logic smp_bad;

  assign smp_bad   = smp_vld && !sync_mode && !smp_agree(smp);
  assign chr_noisy = !sync_mode && (seen_q || smp_bad);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       seen_q <= 1'b0;
    else if (chr_vld) seen_q <= 1'b0;
    else if (smp_bad) seen_q <= 1'b1;
  end
endmodule

// File: rtl/rxs_classify.sv
module rxs_classify #(
  parameter int DATA_W = 8
) (
  input  logic              chr_vld,
  input  logic [DATA_W-1:0] chr_data,
  input  logic              par_bad,
  input  logic              cd_ctl_en,
  input  logic              cd_lost,
  input  logic              fifo_full,
  input  logic              mdrop_mode,
  input  logic              noisy,
  output rxs_pkg::chr_evt_t evt
);
  import rxs_pkg::*;

  logic cdl;
  logic all_ones;
  err_e err;

  assign cdl      = cd_ctl_en && cd_lost;
  assign all_ones = &chr_data;
  assign err      = pick_err(cdl, fifo_full, par_bad);

  always_comb begin
    evt           = '0;
    evt.err       = ERR_NONE;
    if (chr_vld) begin
      evt.err       = err;
      evt.idle_step = all_ones && (err == ERR_NONE);
      evt.idle_clr  = !evt.idle_step && !cdl;
      evt.wr        = !cdl && !evt.idle_step;
      evt.hunt      = mdrop_mode && (err != ERR_NONE);
      evt.inc_par   = !cdl && par_bad;
      evt.inc_noise = !cdl && noisy;
    end
  end
endmodule

// File: rtl/rxs_idle_track.sv
module rxs_idle_track #(
  parameter int IDLE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              clr,
  input  logic [IDLE_W-1:0] idle_max,
  output logic              limit_hit
);
  localparam logic [IDLE_W-1:0] CNT_TOP = '1;

  logic [IDLE_W-1:0] cnt_q;
  logic [IDLE_W:0]   cnt_inc;

  assign cnt_inc   = {1'b0, cnt_q} + 1'b1;
  assign limit_hit = step && (idle_max != '0) && (cnt_inc >= {1'b0, idle_max});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clr)            cnt_q <= '0;
    else if (limit_hit)      cnt_q <= '0;
    else if (step && cnt_q != CNT_TOP) cnt_q <= cnt_inc[IDLE_W-1:0];
  end
endmodule

// File: rtl/rxs_sat_cnt.sv
module rxs_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (clr)               cnt <= '0;
    else if (inc && cnt != TOP) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rxs_top.sv
module rxs_top #(
  parameter int DATA_W = 8,
  parameter int IDLE_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_smp_vld,
  input  logic [2:0]        bit_smp,
  input  logic              chr_vld,
  input  logic [DATA_W-1:0] chr_data,
  input  logic              chr_par_bad,
  input  logic              cd_ctl_en,
  input  logic              cd_lost,
  input  logic              fifo_full,
  input  logic              sync_mode,
  input  logic              mdrop_mode,
  input  logic [IDLE_W-1:0] idle_max,
  input  logic              irq_en,
  input  logic              cnt_clr,
  output logic              wr_vld,
  output logic [DATA_W-1:0] wr_data,
  output logic              close_vld,
  output logic              close_ovr,
  output logic              close_cdl,
  output logic              close_par,
  output logic              irq,
  output logic              hunt_req,
  output logic [CNT_W-1:0]  par_cnt,
  output logic [CNT_W-1:0]  noise_cnt
);
  import rxs_pkg::*;

  localparam int N_CNT = 2;

  chr_evt_t         evt;
  logic             chr_noisy;
  logic             idle_hit;
  logic             buf_open;
  logic             close_err;
  logic             close_idle;
  logic             close_now;
  logic [N_CNT-1:0] cnt_inc;
  logic [CNT_W-1:0] cnt_val [N_CNT];

  rxs_noise_track u_noise (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_vld   (bit_smp_vld),
    .smp       (bit_smp),
    .sync_mode (sync_mode),
    .chr_vld   (chr_vld),
    .chr_noisy (chr_noisy)
  );

  rxs_classify #(.DATA_W(DATA_W)) u_class (
    .chr_vld    (chr_vld),
    .chr_data   (chr_data),
    .par_bad    (chr_par_bad),
    .cd_ctl_en  (cd_ctl_en),
    .cd_lost    (cd_lost),
    .fifo_full  (fifo_full),
    .mdrop_mode (mdrop_mode),
    .noisy      (chr_noisy),
    .evt        (evt)
  );

  rxs_idle_track #(.IDLE_W(IDLE_W)) u_idle (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (evt.idle_step),
    .clr       (evt.idle_clr),
    .idle_max  (idle_max),
    .limit_hit (idle_hit)
  );

  assign cnt_inc[0] = evt.inc_par;
  assign cnt_inc[1] = evt.inc_noise;

  for (genvar gi = 0; gi < N_CNT; gi++) begin : g_cnt
    rxs_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .inc   (cnt_inc[gi]),
      .cnt   (cnt_val[gi])
    );
  end

  assign par_cnt   = cnt_val[0];
  assign noise_cnt = cnt_val[1];

  // a carrier loss closes only a buffer that is open; overrun and parity
  // characters are written, so their buffer is always open
  assign close_err  = (evt.err == ERR_OVR) || (evt.err == ERR_PAR) ||
                      ((evt.err == ERR_CDL) && buf_open);
  assign close_idle = idle_hit && buf_open;
  assign close_now  = close_err || close_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_open  <= 1'b0;
      wr_vld    <= 1'b0;
      wr_data   <= '0;
      close_vld <= 1'b0;
      close_ovr <= 1'b0;
      close_cdl <= 1'b0;
      close_par <= 1'b0;
      irq       <= 1'b0;
      hunt_req  <= 1'b0;
    end else begin
      if (close_now)   buf_open <= 1'b0;
      else if (evt.wr) buf_open <= 1'b1;
      wr_vld    <= evt.wr;
      if (evt.wr) wr_data <= chr_data;
      close_vld <= close_now;
      close_ovr <= close_err && (evt.err == ERR_OVR);
      close_cdl <= close_err && (evt.err == ERR_CDL);
      close_par <= close_err && (evt.err == ERR_PAR);
      irq       <= close_now && irq_en;
      hunt_req  <= evt.hunt;
    end
  end
endmodule

// File: rtl/rxs_checker.sv
module rxs_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             chr_vld,
  input logic             chr_par_bad,
  input logic             cd_ctl_en,
  input logic             cd_lost,
  input logic             sync_mode,
  input logic             mdrop_mode,
  input logic             cnt_clr,
  input logic             wr_vld,
  input logic             close_vld,
  input logic             close_ovr,
  input logic             close_cdl,
  input logic             close_par,
  input logic             irq,
  input logic             hunt_req,
  input logic [CNT_W-1:0] par_cnt,
  input logic [CNT_W-1:0] noise_cnt
);
  localparam logic [CNT_W-1:0] TOP = '1;

  a_r2_cdl_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    chr_vld && cd_ctl_en && cd_lost |=> !wr_vld);

  a_r3_one_status: assert property (@(posedge clk) disable iff (!rst_n)
    close_vld |-> $onehot0({close_ovr, close_cdl, close_par}));

  a_r3_status_needs_close: assert property (@(posedge clk) disable iff (!rst_n)
    (close_ovr || close_cdl || close_par) |-> close_vld);

  a_r6_sync_no_noise: assert property (@(posedge clk) disable iff (!rst_n)
    sync_mode && !cnt_clr |=> $stable(noise_cnt));

  a_r7_no_hunt_outside_mdrop: assert property (@(posedge clk) disable iff (!rst_n)
    !mdrop_mode |=> !hunt_req);

  a_r12_irq_with_close: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> close_vld);

  a_r13_par_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    par_cnt == TOP && !cnt_clr |=> par_cnt == TOP);

  a_r13_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> par_cnt == '0 && noise_cnt == '0);

  a_r14_quiet_without_char: assert property (@(posedge clk) disable iff (!rst_n)
    !chr_vld |=> !wr_vld && !close_vld && !hunt_req && !irq);

  a_r4_par_counts: assert property (@(posedge clk) disable iff (!rst_n)
    chr_vld && chr_par_bad && !(cd_ctl_en && cd_lost) && !cnt_clr && par_cnt != TOP
    |=> par_cnt != $past(par_cnt));
endmodule

bind rxs_top rxs_checker #(.CNT_W(CNT_W)) u_rxs_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .chr_vld     (chr_vld),
  .chr_par_bad (chr_par_bad),
  .cd_ctl_en   (cd_ctl_en),
  .cd_lost     (cd_lost),
  .sync_mode   (sync_mode),
  .mdrop_mode  (mdrop_mode),
  .cnt_clr     (cnt_clr),
  .wr_vld      (wr_vld),
  .close_vld   (close_vld),
  .close_ovr   (close_ovr),
  .close_cdl   (close_cdl),
  .close_par   (close_par),
  .irq         (irq),
  .hunt_req    (hunt_req),
  .par_cnt     (par_cnt),
  .noise_cnt   (noise_cnt)
);

// File: tb/test_rxs_top.sv
`timescale 1ns/1ps
module test_rxs_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_smp_vld = 1'b0;
  logic [2:0]  bit_smp = 3'b000;
  logic        chr_vld = 1'b0;
  logic [7:0]  chr_data = 8'h00;
  logic        chr_par_bad = 1'b0;
  logic        cd_ctl_en = 1'b0;
  logic        cd_lost = 1'b0;
  logic        fifo_full = 1'b0;
  logic        sync_mode = 1'b0;
  logic        mdrop_mode = 1'b0;
  logic [15:0] idle_max = 16'd0;
  logic        irq_en = 1'b1;
  logic        cnt_clr = 1'b0;
  logic        wr_vld, close_vld, close_ovr, close_cdl, close_par, irq, hunt_req;
  logic [7:0]  wr_data;
  logic [15:0] par_cnt, noise_cnt;

  always #2.5 clk = ~clk;

  rxs_top i_rxs_top (.*);

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // reference state
  bit m_open, m_noisy;
  int m_idle, m_par, m_noise;
  int m_wrd;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick(input string req);
    bit e_wr = 0, e_cl = 0, e_ovr = 0, e_cdl = 0, e_par = 0, e_irq = 0, e_hunt = 0;
    bit nz_now, nz, cd, idle;
    if (!rst_n) begin
      m_open = 0; m_noisy = 0; m_idle = 0; m_par = 0; m_noise = 0; m_wrd = 0;
    end else begin
      nz_now = bit_smp_vld && !sync_mode && !(bit_smp == 3'b000 || bit_smp == 3'b111);
      if (chr_vld) begin
        nz = !sync_mode && (m_noisy || nz_now);
        cd = cd_ctl_en && cd_lost;
        m_noisy = 0;
        if (cd) begin
          if (m_open) begin e_cl = 1; e_cdl = 1; m_open = 0; end
          e_hunt = mdrop_mode;
        end else begin
          if (chr_par_bad && m_par < 65535) m_par++;
          if (nz && m_noise < 65535) m_noise++;
          idle = (chr_data == 8'hFF) && !fifo_full && !chr_par_bad;
          if (idle) begin
            if (m_idle < 65535) m_idle++;
            if (idle_max != 0 && m_idle >= idle_max) begin
              m_idle = 0;
              if (m_open) begin e_cl = 1; m_open = 0; end
            end
          end else begin
            m_idle = 0;
            e_wr = 1; m_wrd = chr_data; m_open = 1;
            if (fifo_full) begin e_cl = 1; e_ovr = 1; m_open = 0; end
            else if (chr_par_bad) begin e_cl = 1; e_par = 1; m_open = 0; end
            e_hunt = mdrop_mode && (fifo_full || chr_par_bad);
          end
        end
        e_irq = e_cl && irq_en;
      end else if (nz_now) m_noisy = 1;
      if (cnt_clr) begin m_par = 0; m_noise = 0; end
    end
    @(posedge clk); #1;
    chk(req, "wr_vld", wr_vld, e_wr);
    if (e_wr) chk(req, "wr_data", wr_data, m_wrd);
    chk(req, "close_vld", close_vld, e_cl);
    chk(req, "close_ovr", close_ovr, e_ovr);
    chk(req, "close_cdl", close_cdl, e_cdl);
    chk(req, "close_par", close_par, e_par);
    chk(req, "irq", irq, e_irq);
    chk(req, "hunt_req", hunt_req, e_hunt);
    chk(req, "par_cnt", par_cnt, m_par);
    chk(req, "noise_cnt", noise_cnt, m_noise);
  endtask

  // eight sampled bits, then the character strobe; bit nbit gets samples nsmp
  task automatic send(input string req, input logic [7:0] d, input bit pbad,
                      input int nbit = -1, input logic [2:0] nsmp = 3'b010);
    for (int b = 0; b < 8; b++) begin
      bit_smp_vld = 1; bit_smp = (b == nbit) ? nsmp : {3{d[b]}};
      tick(req);
    end
    bit_smp_vld = 0;
    chr_vld = 1; chr_data = d; chr_par_bad = pbad;
    tick(req);
    chr_vld = 0; chr_par_bad = 0;
    tick(req);
  endtask

  initial begin
    #750000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) tick("R1");
    rst_n = 1;
    tick("R1");

    // R14 clean character, latency
    send("R14", 8'h41, 0);
    // R5 noisy bit
    send("R5", 8'h12, 0, 3, 3'b010);
    send("R5", 8'h00, 0, 0, 3'b100);
    // R6 synchronous mode ignores disagreement
    sync_mode = 1;
    send("R6", 8'h34, 0, 5, 3'b011);
    sync_mode = 0;
    // R4 parity close
    send("R4", 8'h55, 1);
    // R3 overrun outranks parity
    send("R12", 8'h10, 0);
    fifo_full = 1;
    send("R3", 8'h66, 1);
    fifo_full = 0;
    // R2 carrier lost with an open buffer, bad parity and noise too
    send("R2", 8'h20, 0);
    cd_ctl_en = 1; cd_lost = 1;
    send("R2", 8'h21, 1, 2, 3'b001);
    // R2 carrier lost with no buffer open
    send("R2", 8'h22, 0);
    cd_lost = 0;
    // carrier flag ignored without control enable
    cd_ctl_en = 0; cd_lost = 1;
    send("R2", 8'h23, 0);
    cd_lost = 0;
    // R7 multidrop hunt
    mdrop_mode = 1;
    send("R7", 8'h31, 1);
    send("R7", 8'h32, 0, 1, 3'b110);
    fifo_full = 1; send("R7", 8'h33, 0); fifo_full = 0;
    cd_ctl_en = 1; cd_lost = 1; send("R7", 8'h34, 0); cd_lost = 0; cd_ctl_en = 0;
    mdrop_mode = 0;
    // R8 idle run closes open buffer
    idle_max = 16'd3;
    send("R8", 8'h40, 0);
    repeat (3) send("R8", 8'hFF, 0);
    // R12 close without interrupt when disabled
    irq_en = 0;
    send("R12", 8'h41, 0);
    repeat (3) send("R12", 8'hFF, 0);
    irq_en = 1;
    // R10 data byte restarts idle run
    send("R10", 8'h42, 0);
    repeat (2) send("R10", 8'hFF, 0);
    send("R10", 8'h00, 0);
    repeat (2) send("R10", 8'hFF, 0);
    send("R10", 8'hFF, 0);
    // R11 limit reached with no buffer open
    repeat (4) send("R11", 8'hFF, 0);
    // R8 all-ones with bad parity is data, not idle
    send("R8", 8'hFF, 1);
    // R9 zero limit disables idle close
    idle_max = 16'd0;
    send("R9", 8'h43, 0);
    repeat (8) send("R9", 8'hFF, 0);
    // R13 saturation of the parity counter, then clear
    chr_vld = 1; chr_par_bad = 1; chr_data = 8'h5A;
    for (int k = 0; k < 65540; k++) tick("R13");
    chr_vld = 0; chr_par_bad = 0;
    tick("R13");
    chk("R13", "par_cnt saturated", par_cnt, 65535);
    chr_vld = 1; chr_par_bad = 1; cnt_clr = 1;
    tick("R13");
    chr_vld = 0; chr_par_bad = 0; cnt_clr = 0;
    tick("R13");
    chk("R13", "par_cnt cleared", par_cnt, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule